// File: doc/BRIEF.md
# Subcode Serial Output Port

This block hands the P and Q subcode bits of every decoded frame to an external reader, one bit at a time, over a two-wire serial link made of a data line and a data clock. Each decoded frame arrives as a one-cycle strobe together with that frame's subcode byte. The block latches the P bit (byte bit 7) and the Q bit (byte bit 6), pulses a frame sync output, and pulses a block sync output when the frame opens a subcode block. It also presents a flag that reports whether the Q-channel CRC check of the block passed.

A mode input sets the direction of the data clock. In clock-output mode the block drives two clock pulses after each frame sync. Their high and low times are a base half period at normal speed, half of that at double speed and a quarter of it at quadruple speed. In clock-input mode the reader supplies the clock. The block synchronizes that clock and moves the data line from P to Q on the first rising edge it sees.

Top module: `subcode_serial_port`

## Requirements
- R1: After reset, fsync, bsync, sdata, sclk_o and q_ok are all low.
- R2: A frame strobe sampled at a clock edge makes fsync high for exactly the next cycle.
- R3: bsync is high in the same cycle as fsync when blk_start was high with the strobe, and stays low for other frames.
- R4: Right after each frame sync, sdata carries the P bit, which is bit 7 of the strobed byte.
- R5: In clock-output mode (clk_out_mode = 1) sclk_oe is high. sclk_o then gives two pulses that start with fsync: high H cycles, low H, high H, low H, then it stays low. H is BASE_HALF for speed 0, BASE_HALF/2 for speed 1, and BASE_HALF/4 for speed 2 or 3.
- R6: In clock-output mode, sdata switches to the Q bit (bit 7-1 = bit 6 of the byte) on the falling edge of the first pulse and holds it until the next strobe.
- R7: In clock-input mode (clk_out_mode = 0), sclk_oe and sclk_o stay low. The first rising edge on sclk_i after a strobe moves sdata to Q within 4 cycles, and later edges leave it at Q.
- R8: P and Q are latched at the strobe, so changing sub_byte between strobes does not change sdata.
- R9: q_ok takes the crc_good value sampled with a block-start strobe one cycle after that strobe's bsync. crc_good on other frames is ignored, and q_ok holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe for each decoded frame |
| blk_start | input | 1 | Frame is the first of a subcode block (valid with strobe) |
| sub_byte | input | 8 | Subcode byte, P in bit 7, Q in bit 6 |
| crc_good | input | 1 | Q-channel CRC passed (valid with a block-start strobe) |
| clk_out_mode | input | 1 | 1: block drives the data clock; 0: reader drives it |
| speed | input | 2 | Playback speed: 0 normal, 1 double, 2/3 quadruple |
| sclk_i | input | 1 | Data clock from the reader (input mode) |
| fsync | output | 1 | Frame sync pulse |
| bsync | output | 1 | Block sync pulse |
| sdata | output | 1 | Serial subcode data |
| sclk_o | output | 1 | Generated data clock (output mode) |
| sclk_oe | output | 1 | Drive enable for the data clock pin |
| q_ok | output | 1 | Q-channel CRC pass flag |

## Verification
The bench sets up random frames with random mode, speed, byte, block-start and CRC values. It measures the whole pulse train cycle by cycle for every speed code. A design that scaled the half period wrongly, or that gave one pulse or three, would show a sclk_o sample at the wrong level. The bench overwrites sub_byte right after each strobe, which exposes a data path that reads the live byte instead of the latch. In input mode the bench gives extra reader clocks, which catches a design that toggles back to P or walks past Q. It also changes crc_good on frames that are not block starts, which catches a flag that updates on every frame.

// File: rtl/subcode_serial_port.sv
module subcode_serial_port #(
  parameter int BASE_HALF = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_stb,
  input  logic       blk_start,
  input  logic [7:0] sub_byte,
  input  logic       crc_good,
  input  logic       clk_out_mode,
  input  logic [1:0] speed,
  input  logic       sclk_i,
  output logic       fsync,
  output logic       bsync,
  output logic       sdata,
  output logic       sclk_o,
  output logic       sclk_oe,
  output logic       q_ok
);
  localparam int CW = $clog2(BASE_HALF + 1);
  localparam logic [CW-1:0] H1 = CW'(BASE_HALF);
  localparam logic [CW-1:0] H2 = CW'(BASE_HALF / 2);
  localparam logic [CW-1:0] H4 = CW'(BASE_HALF / 4);

  logic          p_r, q_r, crc_cap, bit_idx, active;
  logic [1:0]    phase;
  logic [CW-1:0] cnt, half_len;
  logic [2:0]    ext_s;
  logic          ext_rise;

  assign half_len = (speed == 2'd0) ? H1 : (speed == 2'd1) ? H2 : H4;
  assign ext_rise = ext_s[1] & ~ext_s[2];
  assign sdata    = bit_idx ? q_r : p_r;
  assign sclk_o   = active & ~phase[0];
  assign sclk_oe  = clk_out_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsync <= 1'b0; bsync <= 1'b0; q_ok <= 1'b0;
      p_r <= 1'b0; q_r <= 1'b0; crc_cap <= 1'b0;
      bit_idx <= 1'b0; active <= 1'b0; phase <= 2'd0;
      cnt <= '0; ext_s <= 3'd0;
    end else begin
      ext_s <= {ext_s[1:0], sclk_i};
      fsync <= frame_stb;
      bsync <= frame_stb & blk_start;
      if (bsync) q_ok <= crc_cap;
      if (frame_stb) begin
        p_r     <= sub_byte[7];
        q_r     <= sub_byte[6];
        crc_cap <= crc_good;
        bit_idx <= 1'b0;
        active  <= clk_out_mode;
        phase   <= 2'd0;
        cnt     <= '0;
      end else begin
        if (active) begin
          if (cnt == half_len - 1'b1) begin
            cnt   <= '0;
            phase <= phase + 2'd1;
            if (phase == 2'd0) bit_idx <= 1'b1;
            if (phase == 2'd3) active <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (!clk_out_mode && ext_rise) bit_idx <= 1'b1;
      end
    end
  end

  // R2
  fsync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync && !frame_stb |=> !fsync);

  // R3
  bsync_with_fsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsync |-> fsync);

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $past(frame_stb) || $past(phase) == 2'd1);

  // R6
  data_back_to_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bit_idx) |-> $past(frame_stb));

  // R7
  input_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_out_mode && $past(!clk_out_mode) && !fsync |-> !sclk_o);

  // R9
  ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bsync) |-> $stable(q_ok));
endmodule

// File: tb/subcode_serial_port_tb_top.sv
module subcode_serial_port_tb_top;
  localparam int BASE = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_stb = 0, blk_start = 0, crc_good = 0, clk_out_mode = 0, sclk_i = 0;
  logic [7:0] sub_byte = 8'h00;
  logic [1:0] speed = 2'd0;
  logic fsync, bsync, sdata, sclk_o, sclk_oe, q_ok;
  int checks = 0, fails = 0;
  logic exp_ok = 1'b0;

  subcode_serial_port #(.BASE_HALF(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .blk_start(blk_start),
    .sub_byte(sub_byte), .crc_good(crc_good), .clk_out_mode(clk_out_mode),
    .speed(speed), .sclk_i(sclk_i), .fsync(fsync), .bsync(bsync), .sdata(sdata),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .q_ok(q_ok));

  always #10 clk = ~clk;

  function automatic int half_of(input logic [1:0] s);
    return (s == 2'd0) ? BASE : (s == 2'd1) ? BASE / 2 : BASE / 4;
  endfunction

  function automatic logic clk_exp(input int i, input int h);
    return (i < h) || (i >= 2 * h && i < 3 * h);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic mode, input logic [1:0] spd, input logic [7:0] b,
                           input logic blk, input logic crc);
    int h;
    logic bad;
    logic p, q;
    p = b[7]; q = b[6];
    h = half_of(spd);
    @(negedge clk);
    clk_out_mode = mode; speed = spd; sub_byte = b; blk_start = blk;
    crc_good = crc; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    chk("R2 fsync high", fsync, 1'b1);
    chk("R3 bsync", bsync, blk);
    chk("R4 P bit", sdata, p);
    sub_byte = ~b;        // R8: live byte changes must not reach sdata
    crc_good = ~crc;
    if (blk) exp_ok = crc;
    @(negedge clk);
    chk("R2 fsync single", fsync, 1'b0);
    chk("R9 q_ok", q_ok, exp_ok);
    if (mode) begin
      bad = 1'b0;
      chk("R5 sclk_oe", sclk_oe, 1'b1);
      for (int i = 1; i < 4 * h + 6; i++) begin
        if (sclk_o !== clk_exp(i, h)) bad = 1'b1;
        if (sdata !== ((i < h) ? p : q)) bad = 1'b1;
        if (i < 4 * h + 5) @(negedge clk);
      end
      chk("R5 pulse train", bad, 1'b0);
      chk("R6 R8 Q held", sdata, q);
    end else begin
      chk("R7 sclk_oe low", sclk_oe, 1'b0);
      chk("R7 sclk_o low", sclk_o, 1'b0);
      repeat (3) @(negedge clk);
      chk("R4 R8 P before reader clock", sdata, p);
      for (int k = 0; k < 3; k++) begin
        sclk_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 Q after reader edge", sdata, q);
        sclk_i = 1'b0;
        repeat (3) @(negedge clk);
      end
      chk("R7 sclk_o stays low", sclk_o, 1'b0);
    end
    chk("R9 q_ok hold", q_ok, exp_ok);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 fsync reset", fsync, 1'b0);
    chk("R1 bsync reset", bsync, 1'b0);
    chk("R1 sdata reset", sdata, 1'b0);
    chk("R1 sclk_o reset", sclk_o, 1'b0);
    chk("R1 q_ok reset", q_ok, 1'b0);
    rst_n = 1'b1;
    // directed corners: every speed in output mode, input mode, non-block crc
    run_frame(1'b1, 2'd0, 8'h80, 1'b1, 1'b1);
    run_frame(1'b1, 2'd1, 8'h40, 1'b0, 1'b0);
    run_frame(1'b1, 2'd2, 8'hC0, 1'b0, 1'b0);
    run_frame(1'b1, 2'd3, 8'h80, 1'b1, 1'b0);
    run_frame(1'b0, 2'd0, 8'h40, 1'b1, 1'b1);
    run_frame(1'b0, 2'd2, 8'h80, 1'b0, 1'b0);
    for (int n = 0; n < 60; n++) begin
      run_frame(1'($urandom), 2'($urandom), 8'($urandom),
                ($urandom % 4) == 0, 1'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule